// File: doc/BRIEF.md
# Interrupt Status and Enable-Mask Register Bank

This block is the interrupt register group of a serial peripheral. It holds seven latched status bits that the datapath sets and software clears by writing ones. It also holds an enable mask that cannot be written directly: software sets mask bits through one strobe address, clears them through another, and reads the result from a third, read-only address. A single interrupt line is high while any status bit is set and enabled.

The datapath supplies the raw conditions. These are a mode-fault pulse, the transmit FIFO fill level, a transmit-full level, a receive-not-empty level, and three spare sources. The block compares the transmit level against a programmable threshold to produce the over-watermark condition. Register access uses a simple single-cycle port. A write is taken on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Address encoding (`reg_addr`): 0 = status, 1 = enable strobe, 2 = disable strobe, 3 = mask view, 4 = transmit threshold.

Top module: `irq_reg_bank`

## Requirements
- R1: After reset, status reads 0, mask reads 0, threshold reads 1 and `irq` is low.
- R2: Status, enable, disable and mask share one layout. Bit 1 is mode fault (`ev_mode_fault`), bit 2 is transmit over-watermark, bit 3 is transmit full (`tx_full`) and bit 4 is receive not empty (`rx_not_empty`). Bits 0, 5 and 6 are set by `ev_spare[0]`, `ev_spare[1]` and `ev_spare[2]` respectively.
- R3: A write to address 1 sets every mask bit whose data bit is 1. All other mask bits keep their value.
- R4: A write to address 2 clears every mask bit whose data bit is 1. All other mask bits keep their value.
- R5: Address 3 reads the current mask, and a write to address 3 leaves the mask unchanged. Reads of addresses 1 and 2 return 0.
- R6: An active source sets its status bit on the next clock edge. The bit then stays set after the source goes away, until software clears it.
- R7: A write to address 0 clears every status bit whose data bit is 1 and leaves the others unchanged.
- R8: If a source is active in the same cycle as a write-1-to-clear of its bit, the bit remains set.
- R9: Level sources set their bit again on every cycle their condition holds. Clearing such a bit while the condition persists leaves it set.
- R10: `irq` is high exactly when some bit of (status AND mask) is 1. It follows the registers with no further delay.
- R11: Address 4 holds the transmit threshold, which is writable and readable. The over-watermark source is active while `tx_level` is strictly below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_mode_fault | input | 1 | Mode-fault event pulse |
| tx_level | input | 8 | Transmit FIFO fill level |
| tx_full | input | 1 | Transmit FIFO full level |
| rx_not_empty | input | 1 | Receive FIFO not empty level |
| ev_spare | input | 3 | Spare sources for bits 0, 5, 6 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a source that is active in exactly the cycle a clear write lands. The bench reaches it by driving the source input and the status write in the same half-cycle, so both meet at one clock edge. The same approach holds a level source high across a clear write. The status, mask and clear patterns are swept across all 128 seven-bit values, with related mask and clear patterns derived arithmetically. The over-watermark comparison is probed on both sides of the threshold.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int N_SRC = 7;

    // Register address map.
    typedef enum logic [2:0] {
        A_STAT = 3'd0,
        A_ENA  = 3'd1,
        A_DIS  = 3'd2,
        A_MASK = 3'd3,
        A_THR  = 3'd4
    } reg_addr_e;

    // Shared bit layout for status, enable, disable and mask.
    localparam int B_SPARE0 = 0;
    localparam int B_MODF   = 1;
    localparam int B_TXOW   = 2;
    localparam int B_TXFULL = 3;
    localparam int B_RXNE   = 4;
    localparam int B_SPARE1 = 5;
    localparam int B_SPARE2 = 6;

endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
    import irq_bank_pkg::*;
#(
    parameter int TH_W = 8
) (
    input  logic            ev_mode_fault,
    input  logic [TH_W-1:0] tx_level,
    input  logic [TH_W-1:0] thr_q,
    input  logic            tx_full,
    input  logic            rx_not_empty,
    input  logic [2:0]      ev_spare,
    output logic [N_SRC-1:0] set_vec
);

    logic below_mark;

    always_comb begin
        below_mark        = (tx_level < thr_q);
        set_vec           = '0;
        set_vec[B_SPARE0] = ev_spare[0];
        set_vec[B_MODF]   = ev_mode_fault;
        set_vec[B_TXOW]   = below_mark;
        set_vec[B_TXFULL] = tx_full;
        set_vec[B_RXNE]   = rx_not_empty;
        set_vec[B_SPARE1] = ev_spare[1];
        set_vec[B_SPARE2] = ev_spare[2];
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] status_q
);

    // One flop per source: set has priority over write-1-to-clear.
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] en_vec,
    input  logic [N_SRC-1:0] dis_vec,
    output logic [N_SRC-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | en_vec) & ~dis_vec;
        end
    end

    assert_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec != '0 && dis_vec == '0) |=> ((mask_q & $past(en_vec)) == $past(en_vec)));

    assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_vec != '0) |=> ((mask_q & $past(dis_vec)) == '0));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0 && dis_vec == '0) |=> $stable(mask_q));

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_mode_fault,
    input  logic [TH_W-1:0]   tx_level,
    input  logic              tx_full,
    input  logic              rx_not_empty,
    input  logic [2:0]        ev_spare,
    output logic              irq
);

    localparam logic [TH_W-1:0] THR_RESET = TH_W'(1);

    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] en_vec;
    logic [N_SRC-1:0] dis_vec;
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] mask_q;
    logic [TH_W-1:0]  thr_q;
    logic [N_SRC-1:0] wbits;

    assign wbits = reg_wdata[N_SRC-1:0];

    // Write decode into per-bank strobe vectors.
    always_comb begin
        clr_vec = '0;
        en_vec  = '0;
        dis_vec = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                A_STAT:  clr_vec = wbits;
                A_ENA:   en_vec  = wbits;
                A_DIS:   dis_vec = wbits;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_RESET;
        end else if (reg_wr && reg_addr == A_THR) begin
            thr_q <= reg_wdata[TH_W-1:0];
        end
    end

    irq_event_map #(.TH_W(TH_W)) u_map (
        .ev_mode_fault (ev_mode_fault),
        .tx_level      (tx_level),
        .thr_q         (thr_q),
        .tx_full       (tx_full),
        .rx_not_empty  (rx_not_empty),
        .ev_spare      (ev_spare),
        .set_vec       (set_vec)
    );

    irq_status_bank u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    irq_mask_bank u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_vec  (en_vec),
        .dis_vec (dis_vec),
        .mask_q  (mask_q)
    );

    always_comb begin
        unique case (reg_addr)
            A_STAT:  reg_rdata = DATA_W'(status_q);
            A_MASK:  reg_rdata = DATA_W'(mask_q);
            A_THR:   reg_rdata = DATA_W'(thr_q);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(status_q & mask_q);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    assert_mask_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK) |=> $stable(mask_q));

endmodule

// File: tb/irq_reg_bank_tb.sv
module irq_reg_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ev_mode_fault = 1'b0;
    logic [7:0] tx_level = 8'd5;
    logic       tx_full = 1'b0;
    logic       rx_not_empty = 1'b0;
    logic [2:0] ev_spare = 3'd0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    irq_reg_bank u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ev_mode_fault (ev_mode_fault),
        .tx_level      (tx_level),
        .tx_full       (tx_full),
        .rx_not_empty  (rx_not_empty),
        .ev_spare      (ev_spare),
        .irq           (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive_events(input logic [6:0] b);
        ev_mode_fault = b[1];
        tx_level      = b[2] ? 8'd0 : 8'd5;
        tx_full       = b[3];
        rx_not_empty  = b[4];
        ev_spare      = {b[6], b[5], b[0]};
    endtask

    task automatic pulse_events(input logic [6:0] b);
        drive_events(b);
        @(negedge clk);
        drive_events(7'd0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R1 status reset", v, 8'h00);
        rd(3'd3, v); chk("R1 mask reset", v, 8'h00);
        rd(3'd4, v); chk("R1 thr reset", v, 8'h01);
        chk("R1 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v); chk("R1 status after reset", v, 8'h00);
        rd(3'd4, v); chk("R1 thr after reset", v, 8'h01);

        // Mask sweep: enable and disable strobes.
        for (int p = 0; p < 128; p++) begin
            logic [6:0] q;
            q = 7'((p * 37 + 5) & 127);
            wr(3'd2, 8'h7F);
            wr(3'd1, 8'(p));
            rd(3'd3, v); chk("R3 enable sets mask", v, 8'(p));
            wr(3'd1, 8'(q));
            rd(3'd3, v); chk("R3 enable zeros keep", v, 8'(p | q));
            wr(3'd2, 8'(q));
            rd(3'd3, v); chk("R4 disable clears", v, 8'(p & ~q));
            wr(3'd3, 8'h7F);
            rd(3'd3, v); chk("R5 mask write ignored", v, 8'(p & ~q));
        end
        rd(3'd1, v); chk("R5 enable reads zero", v, 8'h00);
        rd(3'd2, v); chk("R5 disable reads zero", v, 8'h00);

        // Status sweep: latch, irq, write-1-to-clear.
        for (int s = 0; s < 128; s++) begin
            logic [6:0] m;
            logic [6:0] c;
            m = 7'((s * 53 + 11) & 127);
            c = 7'((s * 29 + 3) & 127);
            wr(3'd0, 8'h7F);
            pulse_events(7'(s));
            @(negedge clk);
            rd(3'd0, v); chk("R2 R6 status latched", v, 8'(s));
            wr(3'd2, 8'h7F);
            wr(3'd1, 8'(m));
            chk("R10 irq", irq, |(7'(s) & m));
            wr(3'd0, 8'(c));
            rd(3'd0, v); chk("R7 w1c", v, 8'(7'(s) & ~c));
            chk("R10 irq after clear", irq, |(7'(s) & ~c & m));
        end

        // Set wins over clear in the same cycle.
        wr(3'd0, 8'h7F);
        ev_mode_fault = 1'b1;
        wr(3'd0, 8'h02);
        ev_mode_fault = 1'b0;
        rd(3'd0, v); chk("R8 set beats clear", v, 8'h02);
        wr(3'd0, 8'h02);
        rd(3'd0, v); chk("R7 clear after event gone", v, 8'h00);

        // Level source persists through clears.
        tx_full = 1'b1;
        @(negedge clk);
        wr(3'd0, 8'h08);
        @(negedge clk);
        rd(3'd0, v); chk("R9 level resets bit", v, 8'h08);
        tx_full = 1'b0;
        @(negedge clk);
        wr(3'd0, 8'h08);
        rd(3'd0, v); chk("R9 cleared after level drops", v, 8'h00);

        // Threshold compare.
        wr(3'd4, 8'd6);
        rd(3'd4, v); chk("R11 thr readback", v, 8'd6);
        tx_level = 8'd5;
        @(negedge clk);
        tx_level = 8'd9;
        @(negedge clk);
        rd(3'd0, v); chk("R11 below threshold sets", v, 8'h04);
        wr(3'd0, 8'h04);
        wr(3'd4, 8'd5);
        tx_level = 8'd5;
        repeat (2) @(negedge clk);
        rd(3'd0, v); chk("R11 equal does not set", v, 8'h00);
        tx_level = 8'd5;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule